// File: doc/BRIEF.md
# Per-Crossing Trigger Decision Unit

This block lives in the central timing unit. It reaches one keep/drop decision for every bunch crossing. During a crossing window each aggregation board may present one status word, made of a hit count and an accept bit, together with a valid strobe. A crossing strobe closes the window. At that moment the block takes a snapshot of the window contents, the external tagger bit and the configuration. It then evaluates the decision and issues it a fixed number of clock cycles later, tagged with a running crossing number.

Three decision modes share the same pipeline:

- **Count mode** sums the hit counts of the enabled boards and compares the sum against a programmable threshold.
- **Tagger mode** follows the hardware tagger bit.
- **Remote mode** accepts when any enabled board reported accept.

If an enabled board sent nothing during the window, an error flag is raised on that crossing's decision.

Top module: `xing_trigger_unit`

## Requirements
- R1: After reset, `dec_valid`, `dec_keep` and `dec_missing` are low and `dec_xing` is zero.
- R2: Each cycle in which `xing_strobe` is high produces exactly one decision. `dec_valid` is high for exactly one cycle, LAT cycles after the strobe cycle, in every mode and for any input values. `dec_keep` and `dec_missing` are never high without `dec_valid`.
- R3: The first decision after reset carries crossing number 0. Each later decision carries the previous number plus one, wrapping modulo 2^XING_W.
- R4: Mode is selected by `cfg_mode`. In count mode (`cfg_mode`=0) the decision is keep only when the sum of the enabled boards' counts is strictly greater than `cfg_threshold`. A sum equal to the threshold gives release.
- R5: A board whose `cfg_enable` bit is 0 adds nothing to the sum and its accept bit is ignored. Board i's count sits in `stat_count[i*CNT_W +: CNT_W]`.
- R6: In tagger mode (`cfg_mode`=1) the decision equals the value of `tagger_in` in the strobe cycle.
- R7: In remote mode (`cfg_mode`=2) the decision is keep when at least one enabled board's `stat_accept` bit was 1 in its captured word.
- R8: An enabled board that gave no valid word in a window sets `dec_missing` on that crossing's decision. In count and remote modes the decision is then release. In tagger mode the decision still follows the tagger bit.
- R9: A valid word in the strobe cycle belongs to the window being closed. The window is emptied after the strobe. If a board sends more than once in a window, its last word is the one used.
- R10: `cfg_mode`=3 is reserved and always gives release.
- R11: The sum has CNT_W+clog2(N_SRC) bits, so N_SRC boards all at the maximum count do not overflow.
- R12: Mode, threshold, enable mask and tagger are sampled in the strobe cycle. Later changes do not affect that crossing's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xing_strobe | input | 1 | Closes the current crossing window |
| stat_valid | input | N_SRC | Per-board status valid strobe |
| stat_count | input | N_SRC*CNT_W | Per-board hit counts, board i at bits i*CNT_W |
| stat_accept | input | N_SRC | Per-board accept bit |
| tagger_in | input | 1 | External hardware tagger bit |
| cfg_mode | input | 2 | Decision mode: 0 count, 1 tagger, 2 remote, 3 reserved |
| cfg_threshold | input | CNT_W+clog2(N_SRC) | Count threshold |
| cfg_enable | input | N_SRC | Board enable mask |
| dec_valid | output | 1 | Decision strobe |
| dec_keep | output | 1 | Keep (1) or release (0) |
| dec_missing | output | 1 | An enabled board was missing in the window |
| dec_xing | output | XING_W | Crossing number of the decision |

## Verification
The bench builds the block with four boards, 12-bit counts, a 4-bit crossing number and a latency of 5. These values let a few hundred crossings wrap the crossing number many times. They keep the all-maximum sum of 16380 within reach of the threshold edge cases, and they place extra delay stages after the evaluation register. Random crossings mix partial presence, masks, duplicate sends and strobe-cycle arrivals. After every strobe the configuration and tagger are scrambled, so any late sampling shows up in the decision.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        MODE_COUNT  = 2'd0,
        MODE_TAGGER = 2'd1,
        MODE_REMOTE = 2'd2,
        MODE_RSVD   = 2'd3
    } trig_mode_e;

    // Width of a sum of n values of cnt_w bits that cannot overflow.
    function automatic int sum_width(input int cnt_w, input int n);
        return cnt_w + $clog2(n);
    endfunction

    // Modes in which the board data decide the outcome.
    function automatic logic mode_uses_boards(input trig_mode_e m);
        return (m == MODE_COUNT) || (m == MODE_REMOTE);
    endfunction

endpackage

// File: rtl/trig_capture.sv
// Holds one board's last status word within the open crossing window.
module trig_capture #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         close_win,
    input  logic         in_valid,
    input  logic [W-1:0] in_word,
    output logic         out_present,
    output logic [W-1:0] out_word
);

    logic         held_v;
    logic [W-1:0] held_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= 1'b0;
            held_w <= '0;
        end else if (close_win) begin
            held_v <= 1'b0;
        end else if (in_valid) begin
            held_v <= 1'b1;
            held_w <= in_word;
        end
    end

    // A word arriving in the closing cycle still belongs to this window.
    assign out_present = in_valid | held_v;
    assign out_word    = in_valid ? in_word : held_w;

endmodule

// File: rtl/trig_eval.sv
// Forms the keep/missing result from one window snapshot; one register stage.
module trig_eval
    import trig_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int CNT_W = 12,
    parameter int TAG_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  trig_mode_e               in_mode,
    input  logic [sum_width(CNT_W, N_SRC)-1:0] in_thr,
    input  logic [N_SRC-1:0]         in_en,
    input  logic [N_SRC-1:0]         in_pres,
    input  logic [N_SRC-1:0]         in_acc,
    input  logic [N_SRC*CNT_W-1:0]   in_cnt,
    input  logic                     in_tag,
    input  logic [TAG_W-1:0]         in_xing,
    output logic                     out_valid,
    output logic                     out_keep,
    output logic                     out_missing,
    output logic [TAG_W-1:0]         out_xing
);

    localparam int SUM_W = sum_width(CNT_W, N_SRC);

    logic [CNT_W-1:0] masked [N_SRC];
    logic [SUM_W-1:0] hit_sum;
    logic             any_acc;
    logic             missing;
    logic             keep;

    for (genvar i = 0; i < N_SRC; i++) begin : g_mask
        assign masked[i] = in_en[i] ? in_cnt[i*CNT_W +: CNT_W] : '0;
    end

    always_comb begin
        hit_sum = '0;
        for (int i = 0; i < N_SRC; i++) begin
            hit_sum = hit_sum + SUM_W'(masked[i]);
        end
    end

    assign any_acc = |(in_acc & in_en & in_pres);
    assign missing = |(in_en & ~in_pres);

    always_comb begin
        unique case (in_mode)
            MODE_COUNT:  keep = hit_sum > in_thr;
            MODE_TAGGER: keep = in_tag;
            MODE_REMOTE: keep = any_acc;
            default:     keep = 1'b0;
        endcase
        if (missing && mode_uses_boards(in_mode)) begin
            keep = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_keep    <= 1'b0;
            out_missing <= 1'b0;
            out_xing    <= '0;
        end else begin
            out_valid   <= in_valid;
            out_keep    <= in_valid & keep;
            out_missing <= in_valid & missing;
            if (in_valid) begin
                out_xing <= in_xing;
            end
        end
    end

endmodule

// File: rtl/trig_delay.sv
// Fixed-depth alignment line; DEPTH may be zero.
module trig_delay #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    if (DEPTH == 0) begin : g_bypass
        assign q = d;
    end else begin : g_pipe
        logic [DW-1:0] stg [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            end else begin
                stg[0] <= d;
                for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
        end
        assign q = stg[DEPTH-1];
    end

endmodule

// File: rtl/xing_trigger_unit.sv
module xing_trigger_unit
    import trig_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int CNT_W  = 12,
    parameter int XING_W = 16,
    parameter int LAT    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          xing_strobe,
    input  logic [N_SRC-1:0]              stat_valid,
    input  logic [N_SRC*CNT_W-1:0]        stat_count,
    input  logic [N_SRC-1:0]              stat_accept,
    input  logic                          tagger_in,
    input  logic [1:0]                    cfg_mode,
    input  logic [CNT_W+$clog2(N_SRC)-1:0] cfg_threshold,
    input  logic [N_SRC-1:0]              cfg_enable,
    output logic                          dec_valid,
    output logic                          dec_keep,
    output logic                          dec_missing,
    output logic [XING_W-1:0]             dec_xing
);

    localparam int SUM_W   = sum_width(CNT_W, N_SRC);
    localparam int FIELD_W = CNT_W + 1;
    localparam int EXTRA   = LAT - 2;

    typedef struct packed {
        logic                     valid;
        logic                     tag;
        trig_mode_e               mode;
        logic [SUM_W-1:0]         thr;
        logic [N_SRC-1:0]         en;
        logic [N_SRC-1:0]         pres;
        logic [N_SRC-1:0]         acc;
        logic [N_SRC*CNT_W-1:0]   cnt;
        logic [XING_W-1:0]        xing;
    } snap_t;

    typedef struct packed {
        logic              valid;
        logic              keep;
        logic              missing;
        logic [XING_W-1:0] xing;
    } dec_t;

    logic [N_SRC-1:0]       win_pres;
    logic [N_SRC-1:0]       win_acc;
    logic [N_SRC*CNT_W-1:0] win_cnt;
    logic [XING_W-1:0]      xing_ctr;
    snap_t                  snap;
    dec_t                   eval_out;
    dec_t                   dec_out;

    // Per-board window capture
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic [FIELD_W-1:0] word;
        trig_capture #(.W(FIELD_W)) u_cap (
            .clk         (clk),
            .rst         (rst),
            .close_win   (xing_strobe),
            .in_valid    (stat_valid[i]),
            .in_word     ({stat_accept[i], stat_count[i*CNT_W +: CNT_W]}),
            .out_present (win_pres[i]),
            .out_word    (word)
        );
        assign win_acc[i]                 = word[CNT_W];
        assign win_cnt[i*CNT_W +: CNT_W]  = word[CNT_W-1:0];
    end

    // Crossing counter and snapshot at window close
    always_ff @(posedge clk) begin
        if (rst) begin
            xing_ctr <= '0;
            snap     <= '0;
        end else begin
            snap.valid <= xing_strobe;
            if (xing_strobe) begin
                xing_ctr  <= xing_ctr + 1'b1;
                snap.tag  <= tagger_in;
                snap.mode <= trig_mode_e'(cfg_mode);
                snap.thr  <= cfg_threshold;
                snap.en   <= cfg_enable;
                snap.pres <= win_pres;
                snap.acc  <= win_acc;
                snap.cnt  <= win_cnt;
                snap.xing <= xing_ctr;
            end
        end
    end

    trig_eval #(
        .N_SRC (N_SRC),
        .CNT_W (CNT_W),
        .TAG_W (XING_W)
    ) u_eval (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (snap.valid),
        .in_mode     (snap.mode),
        .in_thr      (snap.thr),
        .in_en       (snap.en),
        .in_pres     (snap.pres),
        .in_acc      (snap.acc),
        .in_cnt      (snap.cnt),
        .in_tag      (snap.tag),
        .in_xing     (snap.xing),
        .out_valid   (eval_out.valid),
        .out_keep    (eval_out.keep),
        .out_missing (eval_out.missing),
        .out_xing    (eval_out.xing)
    );

    trig_delay #(
        .DW    ($bits(dec_t)),
        .DEPTH (EXTRA)
    ) u_align (
        .clk (clk),
        .rst (rst),
        .d   (eval_out),
        .q   (dec_out)
    );

    assign dec_valid   = dec_out.valid;
    assign dec_keep    = dec_out.keep;
    assign dec_missing = dec_out.missing;
    assign dec_xing    = dec_out.xing;

endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
    parameter int XING_W = 16,
    parameter int LAT    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              xing_strobe,
    input logic              dec_valid,
    input logic              dec_keep,
    input logic              dec_missing,
    input logic [XING_W-1:0] dec_xing
);

    logic [LAT-1:0]    strobe_hist;
    logic [XING_W-1:0] last_xing;
    logic              seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_hist <= '0;
            last_xing   <= '0;
            seen        <= 1'b0;
        end else begin
            strobe_hist <= {strobe_hist[LAT-2:0], xing_strobe};
            if (dec_valid) begin
                last_xing <= dec_xing;
                seen      <= 1'b1;
            end
        end
    end

    // R2
    fixed_latency_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid == strobe_hist[LAT-1]);

    // R2
    keep_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        dec_keep |-> dec_valid);

    // R8
    missing_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        dec_missing |-> dec_valid);

    // R3
    first_xing_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !seen) |-> (dec_xing == '0));

    // R3
    xing_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && seen) |-> (dec_xing == XING_W'(last_xing + 1'b1)));

endmodule

bind xing_trigger_unit trig_checker #(
    .XING_W (XING_W),
    .LAT    (LAT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .xing_strobe (xing_strobe),
    .dec_valid   (dec_valid),
    .dec_keep    (dec_keep),
    .dec_missing (dec_missing),
    .dec_xing    (dec_xing)
);

// File: tb/sim_xing_trigger_unit.sv
`timescale 1ns/1ps
module sim_xing_trigger_unit;

    localparam int N   = 4;
    localparam int C   = 12;
    localparam int SW  = C + $clog2(N);
    localparam int XW  = 4;
    localparam int LAT = 5;
    localparam int CA  = N * C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xing_strobe = 1'b0;
    logic [N-1:0]  stat_valid = '0;
    logic [CA-1:0] stat_count = '0;
    logic [N-1:0]  stat_accept = '0;
    logic          tagger_in = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [SW-1:0] cfg_threshold = '0;
    logic [N-1:0]  cfg_enable = '0;
    logic          dec_valid;
    logic          dec_keep;
    logic          dec_missing;
    logic [XW-1:0] dec_xing;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [XW-1:0] xexp = '0;

    always #4 clk = ~clk;

    xing_trigger_unit #(
        .N_SRC (N), .CNT_W (C), .XING_W (XW), .LAT (LAT)
    ) u0 (
        .clk (clk), .rst (rst), .xing_strobe (xing_strobe),
        .stat_valid (stat_valid), .stat_count (stat_count),
        .stat_accept (stat_accept), .tagger_in (tagger_in),
        .cfg_mode (cfg_mode), .cfg_threshold (cfg_threshold),
        .cfg_enable (cfg_enable), .dec_valid (dec_valid),
        .dec_keep (dec_keep), .dec_missing (dec_missing),
        .dec_xing (dec_xing)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_keep(input logic [CA-1:0] cnt, input logic [N-1:0] acc,
                                      input logic [N-1:0] pres, input logic [N-1:0] en,
                                      input logic [1:0] mode, input logic [SW-1:0] thr,
                                      input logic tag);
        int  sum = 0;
        logic miss = |(en & ~pres);
        logic anyacc = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (en[i]) begin
                sum += int'(cnt[i*C +: C]);
                if (acc[i] && pres[i]) anyacc = 1'b1;
            end
        end
        case (mode)
            2'd0:    return !miss && (sum > int'(thr));
            2'd1:    return tag;
            2'd2:    return !miss && anyacc;
            default: return 1'b0;
        endcase
    endfunction

    // One crossing: optional early duplicate send, normal sends, strobe-cycle sends.
    task automatic xing(input string req, input logic [CA-1:0] cnt, input logic [N-1:0] acc,
                        input logic [N-1:0] pres, input logic [N-1:0] late,
                        input logic [N-1:0] dup, input logic tag, input logic [1:0] mode,
                        input logic [SW-1:0] thr, input logic [N-1:0] en);
        logic k = exp_keep(cnt, acc, pres, en, mode, thr, tag);
        logic m = |(en & ~pres);
        @(negedge clk);
        stat_valid = dup; stat_count = ~cnt; stat_accept = ~acc;
        @(negedge clk);
        stat_valid = pres & ~late; stat_count = cnt; stat_accept = acc;
        @(negedge clk);
        stat_valid = pres & late; xing_strobe = 1'b1;
        tagger_in = tag; cfg_mode = mode; cfg_threshold = thr; cfg_enable = en;
        @(negedge clk);
        stat_valid = '0; xing_strobe = 1'b0; stat_count = ~cnt; stat_accept = ~acc;
        tagger_in = ~tag; cfg_mode = ~mode; cfg_threshold = ~thr; cfg_enable = ~en;
        repeat (LAT - 2) @(negedge clk);
        chk("R2 early", dec_valid, 0);
        @(negedge clk);
        chk("R2 valid", dec_valid, 1);
        chk("R3 xing", dec_xing, xexp);
        chk(req, dec_keep, k);
        chk("R8 missing", dec_missing, m);
        xexp = xexp + 1'b1;
        @(negedge clk);
        chk("R2 one pulse", dec_valid, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", dec_valid, 0);
        chk("R1 keep", dec_keep, 0);
        chk("R1 missing", dec_missing, 0);
        chk("R1 xing", dec_xing, 0);

        // R4 sum 1000 vs threshold 999 and 1000
        xing("R4 above", {12'd400, 12'd300, 12'd200, 12'd100}, 4'h0, 4'hF, 4'h0, 4'h0, 0, 2'd0, 14'd999, 4'hF);
        xing("R4 equal", {12'd400, 12'd300, 12'd200, 12'd100}, 4'h0, 4'hF, 4'h0, 4'h0, 0, 2'd0, 14'd1000, 4'hF);
        // R5 masked board with a large count and an accept
        xing("R5 sum mask", {12'd4000, 12'd300, 12'd200, 12'd100}, 4'h0, 4'hF, 4'h0, 4'h0, 0, 2'd0, 14'd600, 4'h7);
        xing("R5 acc mask", 48'd0, 4'h8, 4'hF, 4'h0, 4'h0, 0, 2'd2, 14'd0, 4'h7);
        // R6 tagger
        xing("R6 tag set", 48'd0, 4'hF, 4'h0, 4'h0, 4'h0, 1, 2'd1, 14'd0, 4'h0);
        xing("R6 tag clear", {4{12'hFFF}}, 4'hF, 4'h0, 4'h0, 4'h0, 0, 2'd1, 14'd0, 4'h0);
        // R7 remote accepts
        xing("R7 one accept", 48'd0, 4'h2, 4'hF, 4'h0, 4'h0, 0, 2'd2, 14'd0, 4'hF);
        xing("R7 no accept", 48'd0, 4'h0, 4'hF, 4'h0, 4'h0, 1, 2'd2, 14'd0, 4'hF);
        // R8 missing board
        xing("R8 count release", {4{12'hFFF}}, 4'hF, 4'hE, 4'h0, 4'h0, 0, 2'd0, 14'd0, 4'hF);
        xing("R8 remote release", 48'd0, 4'hF, 4'h7, 4'h0, 4'h0, 0, 2'd2, 14'd0, 4'hF);
        xing("R8 tagger keeps", 48'd0, 4'h0, 4'h3, 4'h0, 4'h0, 1, 2'd1, 14'd0, 4'hF);
        // R9 strobe-cycle arrivals, duplicates, empty window afterwards
        xing("R9 late words", {12'd10, 12'd10, 12'd10, 12'd10}, 4'h0, 4'hF, 4'hF, 4'h0, 0, 2'd0, 14'd39, 4'hF);
        xing("R9 last wins", {12'd1, 12'd1, 12'd1, 12'd1}, 4'h0, 4'hF, 4'h5, 4'hF, 0, 2'd0, 14'd4, 4'hF);
        xing("R9 emptied", {4{12'hFFF}}, 4'hF, 4'h0, 4'h0, 4'h0, 0, 2'd0, 14'd0, 4'hF);
        // R10 reserved mode
        xing("R10 reserved", {4{12'hFFF}}, 4'hF, 4'hF, 4'h0, 4'h0, 1, 2'd3, 14'd0, 4'hF);
        // R11 full-scale sum 16380
        xing("R11 max keep", {4{12'hFFF}}, 4'h0, 4'hF, 4'h0, 4'h0, 0, 2'd0, 14'd16379, 4'hF);
        xing("R11 max equal", {4{12'hFFF}}, 4'h0, 4'hF, 4'h0, 4'h0, 0, 2'd0, 14'd16380, 4'hF);
        // R12 config scrambled right after strobe; threshold decides
        xing("R12 sampled", {12'd5, 12'd5, 12'd5, 12'd5}, 4'h0, 4'hF, 4'h0, 4'h0, 0, 2'd0, 14'd19, 4'hF);

        for (int n = 0; n < 200; n++) begin
            logic [CA-1:0] cnt = CA'({$urandom(), $urandom()});
            logic [N-1:0]  en  = N'($urandom());
            logic [N-1:0]  pres = ($urandom_range(0, 3) == 0) ? N'($urandom()) : (en | N'($urandom()));
            logic [N-1:0]  acc = N'($urandom()) & N'($urandom());
            logic [1:0]    mode = 2'($urandom());
            logic [SW-1:0] thr = SW'($urandom_range(0, 16380));
            string req;
            case (mode)
                2'd0: req = "R4 random";
                2'd1: req = "R6 random";
                2'd2: req = "R7 random";
                default: req = "R10 random";
            endcase
            xing(req, cnt, acc, pres, N'($urandom()) & pres, N'($urandom()) & pres,
                 1'($urandom()), mode, thr, en);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule